// File: doc/BRIEF.md
# Serial Port Bit-Clock and Frame-Sync Generator

This block produces the two timing strobes a synchronous serial port needs. The first is a bit-clock enable, a one-cycle pulse for each bit period. The second is a frame marker that repeats at a programmable spacing. Everything runs on a single fast system clock. The three external clock pins and the receive frame-sync pin each pass through a two-flop synchronizer and an edge detector, which turn them into one-cycle enables. The block never uses them as clocks.

A two-bit selector picks the bit timing source. It can be one of the three external pins, or the system clock itself, in which case the block ticks every cycle. For the general-purpose external pin only, a polarity bit picks the active edge, and a resync bit hands frame timing over to the incoming receive frame sync. A frame counter sets the spacing between frame markers. The transmit frame-sync output is taken either from the frame marker or from a transmit-buffer load strobe, or it is held low when transmit framing comes from outside.

The control fields arrive as static inputs from a register elsewhere. They are expected to change only while the block is held in reset.

Top module: `serial_rate_gen`

## Requirements
- R1: `cfg_src_sel` picks the timing source. 2'b00 is `sclk_pin`, 2'b01 is the system clock, 2'b10 is `rxclk_pin` and 2'b11 is `txclk_pin`. The last two always act on their rising edge.
- R2: `cfg_sclk_fall` picks the active edge of `sclk_pin`: 0 for rising, 1 for falling. It has no effect when another source is selected.
- R3: A level change on an external pin that is first sampled at rising edge E0 produces its one-cycle `bit_en` pulse after rising edge E2, two cycles later.
- R4: With the system clock selected, `bit_en` is high on every cycle once the first frame boundary has passed.
- R5: In normal framing, each active source edge either reloads the frame counter from `cfg_period` (n) and raises `frame_pulse`, or decrements the counter and lowers `frame_pulse`. The rise happens when the counter is zero. Rises of `frame_pulse` are therefore n+1 source edges apart, and `frame_pulse` stays high for one bit period (continuously when n = 0).
- R6: After reset the frame counter is zero. `bit_en` and `frame_pulse` stay low until the first active source edge, which is a frame boundary and raises both.
- R7: With `cfg_resync`=1 and `sclk_pin` selected, `cfg_period` is ignored, and nothing is produced until a rising edge on `rxfs_pin` has been detected, with the same latency as R3. The next active source edge then gives the first `bit_en` pulse. The edge after that raises `frame_pulse` for one bit period. Later edges give `bit_en` only, until the next `rxfs_pin` rising edge restarts the sequence.
- R8: When the source is not `sclk_pin`, `cfg_resync` and `rxfs_pin` have no effect, and framing follows R5.
- R9: With `cfg_fsx_internal`=0, `fsx_out` is 0. With `cfg_fsx_internal`=1 and `cfg_fsx_gen`=1, `fsx_out` follows `frame_pulse`. With `cfg_fsx_internal`=1 and `cfg_fsx_gen`=0, `fsx_out` is a copy of `xmit_load` delayed by one cycle.
- R10: `rst_n` is an active-low synchronous reset. It clears all synchronizer, edge and frame state, and holds every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sclk_pin | input | 1 | General-purpose external clock, asynchronous |
| rxclk_pin | input | 1 | Receive-side external clock, asynchronous |
| txclk_pin | input | 1 | Transmit-side external clock, asynchronous |
| rxfs_pin | input | 1 | Receive frame sync, active high, asynchronous |
| xmit_load | input | 1 | One-cycle strobe when the transmit buffer is loaded |
| cfg_src_sel | input | 2 | Timing source select (R1 encoding) |
| cfg_sclk_fall | input | 1 | Use falling edges of `sclk_pin` |
| cfg_resync | input | 1 | Frame timing taken from `rxfs_pin` |
| cfg_fsx_gen | input | 1 | Transmit frame sync from `frame_pulse` (1) or `xmit_load` (0) |
| cfg_fsx_internal | input | 1 | Transmit frame sync produced by this block |
| cfg_period | input | 12 | Frame spacing minus one, in bit periods |
| bit_en | output | 1 | Bit-clock enable, one cycle per bit period |
| frame_pulse | output | 1 | Frame marker, one bit period wide |
| fsx_out | output | 1 | Transmit frame sync |

## Verification
An external pin change is due on `bit_en` and `frame_pulse` three rising edges after it is first sampled. A `rxfs_pin` edge takes the same three edges to arm resync, and it shows only at the next source tick. With the system clock as source, results change one edge after reset is released. `fsx_out` follows `xmit_load` by one edge, and follows the configuration bits at once. The bench drives every input on the falling clock edge. A behavioural model advances on the rising edge, and all outputs are compared with it on the next falling edge, so each result is checked in the cycle it is due.

// File: rtl/srg_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the serial rate generator.
// Assumes: the source-select encoding is fixed by the control register layout.
package srg_pkg;

    // Timing source encoding (two control bits)
    typedef enum logic [1:0] {
        SRC_SCLK  = 2'b00,
        SRC_SYS   = 2'b01,
        SRC_RXCLK = 2'b10,
        SRC_TXCLK = 2'b11
    } srg_src_e;

    // Number of asynchronous pins brought into the clock domain
    localparam int unsigned EXT_NUM = 4;

    // Index of each pin in the packed pin vector
    localparam int unsigned EXT_SCLK  = 0;
    localparam int unsigned EXT_RXCLK = 1;
    localparam int unsigned EXT_TXCLK = 2;
    localparam int unsigned EXT_RXFS  = 3;

endpackage

// File: rtl/srg_sync_edge.sv
`timescale 1ns/1ps
// Module: srg_sync_edge
// Brings one asynchronous pin into the clk domain through STAGES flops.
// One more flop keeps history, and the selected edge is flagged as a
// one-cycle pulse.
// Assumes: the pin stays at each level for at least one clk period.
module srg_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_hit
);
    localparam int unsigned CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;
    logic               now_lvl;
    logic               old_lvl;

    // Shift the pin through the synchronizer and history flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], pin};
        end
    end

    // Compare the synchronized level with the one before it
    always_comb begin
        now_lvl  = chain_q[STAGES-1];
        old_lvl  = chain_q[STAGES];
        edge_hit = fall_sel ? (old_lvl & ~now_lvl) : (now_lvl & ~old_lvl);
    end

endmodule

// File: rtl/srg_src_mux.sv
`timescale 1ns/1ps
// Module: srg_src_mux
// Picks the timing source tick from the external edge pulses or the
// system clock.
// Assumes: the edge inputs are already one-cycle pulses in the clk domain.
module srg_src_mux
    import srg_pkg::*;
(
    input  logic [1:0] src_sel,
    input  logic       sclk_hit,
    input  logic       rxclk_hit,
    input  logic       txclk_hit,
    output logic       tick
);
    srg_src_e sel_e;

    // Four-way source selection
    always_comb begin
        sel_e = srg_src_e'(src_sel);
        unique case (sel_e)
            SRC_SCLK:  tick = sclk_hit;
            SRC_SYS:   tick = 1'b1;
            SRC_RXCLK: tick = rxclk_hit;
            SRC_TXCLK: tick = txclk_hit;
            default:   tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/srg_frame_timer.sv
`timescale 1ns/1ps
// Module: srg_frame_timer
// Turns source ticks into the bit enable and the frame marker.
// In normal framing a down-counter spaces the markers by period+1 ticks.
// In resync framing a receive frame-sync detection arms a restart.
// Assumes: resync_on and period are static outside reset.
module srg_frame_timer #(
    parameter int unsigned PERIOD_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                fsr_hit,
    input  logic                resync_on,
    input  logic [PERIOD_W-1:0] period,
    output logic                bit_en,
    output logic                frame_pulse
);
    logic [PERIOD_W-1:0] cnt_q;
    logic                live_q;
    logic                pend_q;
    logic                armed_q;
    logic                en_q;
    logic                fsg_q;
    logic                cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    // Frame counter, marker level and resync sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            live_q  <= 1'b0;
            pend_q  <= 1'b0;
            armed_q <= 1'b0;
            en_q    <= 1'b0;
            fsg_q   <= 1'b0;
        end else begin
            en_q <= 1'b0;
            if (tick) begin
                if (resync_on) begin
                    if (pend_q) begin
                        en_q    <= 1'b1;
                        live_q  <= 1'b1;
                        armed_q <= 1'b1;
                        pend_q  <= 1'b0;
                        fsg_q   <= 1'b0;
                        cnt_q   <= period;
                    end else if (armed_q) begin
                        en_q    <= live_q;
                        fsg_q   <= 1'b1;
                        armed_q <= 1'b0;
                    end else begin
                        en_q    <= live_q;
                        fsg_q   <= 1'b0;
                    end
                end else if (cnt_zero) begin
                    en_q   <= 1'b1;
                    live_q <= 1'b1;
                    fsg_q  <= 1'b1;
                    cnt_q  <= period;
                end else begin
                    en_q   <= live_q;
                    fsg_q  <= 1'b0;
                    cnt_q  <= cnt_q - 1'b1;
                end
            end
            if (resync_on && fsr_hit) begin
                pend_q  <= 1'b1;
                armed_q <= 1'b0;
            end
        end
    end

    assign bit_en      = en_q;
    assign frame_pulse = fsg_q;

endmodule

// File: rtl/serial_rate_gen.sv
`timescale 1ns/1ps
// Module: serial_rate_gen (top)
// Synchronizes the external pins, selects the timing source, runs the
// frame timer and chooses the transmit frame-sync source.
// Assumes: cfg_* inputs are static outside reset.
module serial_rate_gen
    import srg_pkg::*;
#(
    parameter int unsigned PERIOD_W    = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk_pin,
    input  logic                rxclk_pin,
    input  logic                txclk_pin,
    input  logic                rxfs_pin,
    input  logic                xmit_load,
    input  logic [1:0]          cfg_src_sel,
    input  logic                cfg_sclk_fall,
    input  logic                cfg_resync,
    input  logic                cfg_fsx_gen,
    input  logic                cfg_fsx_internal,
    input  logic [PERIOD_W-1:0] cfg_period,
    output logic                bit_en,
    output logic                frame_pulse,
    output logic                fsx_out
);
    logic [EXT_NUM-1:0] pins;
    logic [EXT_NUM-1:0] fall_mode;
    logic [EXT_NUM-1:0] hits;
    logic               tick;
    logic               resync_on;
    logic               load_q;

    // Pack the pins and give each its edge choice
    always_comb begin
        pins            = '0;
        pins[EXT_SCLK]  = sclk_pin;
        pins[EXT_RXCLK] = rxclk_pin;
        pins[EXT_TXCLK] = txclk_pin;
        pins[EXT_RXFS]  = rxfs_pin;
        fall_mode           = '0;
        fall_mode[EXT_SCLK] = cfg_sclk_fall;
    end

    // One synchronizer and edge detector per pin
    for (genvar gi = 0; gi < EXT_NUM; gi++) begin : g_sync
        srg_sync_edge #(
            .STAGES(SYNC_STAGES)
        ) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin     (pins[gi]),
            .fall_sel(fall_mode[gi]),
            .edge_hit(hits[gi])
        );
    end

    srg_src_mux u_mux (
        .src_sel  (cfg_src_sel),
        .sclk_hit (hits[EXT_SCLK]),
        .rxclk_hit(hits[EXT_RXCLK]),
        .txclk_hit(hits[EXT_TXCLK]),
        .tick     (tick)
    );

    // Resync applies only to the general-purpose pin
    assign resync_on = cfg_resync & (cfg_src_sel == SRC_SCLK);

    srg_frame_timer #(
        .PERIOD_W(PERIOD_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .fsr_hit    (hits[EXT_RXFS]),
        .resync_on  (resync_on),
        .period     (cfg_period),
        .bit_en     (bit_en),
        .frame_pulse(frame_pulse)
    );

    // Register the transmit-buffer load strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= 1'b0;
        end else begin
            load_q <= xmit_load;
        end
    end

    // Transmit frame-sync source choice
    always_comb begin
        if (!cfg_fsx_internal) begin
            fsx_out = 1'b0;
        end else if (cfg_fsx_gen) begin
            fsx_out = frame_pulse;
        end else begin
            fsx_out = load_q;
        end
    end

endmodule

// File: rtl/srg_chk.sv
`timescale 1ns/1ps
// Module: srg_chk
// Property checker bound to serial_rate_gen.
// Assumes: cfg_* inputs are static outside reset.
module srg_chk #(
    parameter int unsigned PERIOD_W = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick,
    input logic                resync_on,
    input logic [1:0]          cfg_src_sel,
    input logic                cfg_fsx_internal,
    input logic                cfg_fsx_gen,
    input logic                xmit_load,
    input logic [PERIOD_W-1:0] cfg_period,
    input logic                bit_en,
    input logic                frame_pulse,
    input logic                fsx_out
);
    logic                past_ok;
    logic                fp_prev;
    logic                have_prev;
    logic [PERIOD_W:0]   gap_q;

    // Marks cycles whose previous cycle was out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    // Counts bit enables between frame marker rises
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fp_prev   <= 1'b0;
            have_prev <= 1'b0;
            gap_q     <= '0;
        end else begin
            fp_prev <= frame_pulse;
            if (frame_pulse && !fp_prev) begin
                gap_q     <= '0;
                have_prev <= 1'b1;
            end else if (bit_en) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    p_en_after_tick_r3: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        bit_en |-> $past(tick));

    p_sys_steady_r4: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (cfg_src_sel == 2'b01 && $past(bit_en)) |-> bit_en);

    p_marker_moves_on_en_r5: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        !$stable(frame_pulse) |-> bit_en);

    p_marker_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!resync_on && frame_pulse && !fp_prev && have_prev) |-> (gap_q == {1'b0, cfg_period}));

    p_fsx_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_fsx_internal |-> !fsx_out);

    p_fsx_load_r9: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (cfg_fsx_internal && !cfg_fsx_gen && $past(xmit_load)) |-> fsx_out);

endmodule

bind serial_rate_gen srg_chk #(
    .PERIOD_W(PERIOD_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .tick            (tick),
    .resync_on       (resync_on),
    .cfg_src_sel     (cfg_src_sel),
    .cfg_fsx_internal(cfg_fsx_internal),
    .cfg_fsx_gen     (cfg_fsx_gen),
    .xmit_load       (xmit_load),
    .cfg_period      (cfg_period),
    .bit_en          (bit_en),
    .frame_pulse     (frame_pulse),
    .fsx_out         (fsx_out)
);

// File: tb/serial_rate_gen_test.sv
`timescale 1ns/1ps
// Bench: behavioural reference model stepped on each rising edge and
// compared with the design on each falling edge.
module serial_rate_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_pin = 1'b0;
    logic        rxclk_pin = 1'b0;
    logic        txclk_pin = 1'b0;
    logic        rxfs_pin = 1'b0;
    logic        xmit_load = 1'b0;
    logic [1:0]  cfg_src_sel = 2'b01;
    logic        cfg_sclk_fall = 1'b0;
    logic        cfg_resync = 1'b0;
    logic        cfg_fsx_gen = 1'b0;
    logic        cfg_fsx_internal = 1'b0;
    logic [11:0] cfg_period = 12'd0;
    logic        bit_en;
    logic        frame_pulse;
    logic        fsx_out;

    int checks = 0;
    int failures = 0;
    bit checking = 0;
    bit done = 0;
    string cur_req = "R10";

    int half_s = 0;
    int half_r = 0;
    int half_x = 0;
    int cyc_n = 0;

    // model state
    int  m_cnt = 0;
    bit  m_live = 0, m_pend = 0, m_armed = 0, m_en = 0, m_fsg = 0, m_load = 0;
    bit  h_s [$], h_r [$], h_x [$], h_f [$];

    serial_rate_gen uut (
        .clk(clk), .rst_n(rst_n),
        .sclk_pin(sclk_pin), .rxclk_pin(rxclk_pin), .txclk_pin(txclk_pin),
        .rxfs_pin(rxfs_pin), .xmit_load(xmit_load),
        .cfg_src_sel(cfg_src_sel), .cfg_sclk_fall(cfg_sclk_fall),
        .cfg_resync(cfg_resync), .cfg_fsx_gen(cfg_fsx_gen),
        .cfg_fsx_internal(cfg_fsx_internal), .cfg_period(cfg_period),
        .bit_en(bit_en), .frame_pulse(frame_pulse), .fsx_out(fsx_out)
    );

    always #2 clk = ~clk;

    // Free-running external pin toggling, driven on the falling edge
    always @(negedge clk) begin
        cyc_n++;
        if (half_s > 0 && cyc_n % half_s == 0) sclk_pin = ~sclk_pin;
        if (half_r > 0 && cyc_n % half_r == 0) rxclk_pin = ~rxclk_pin;
        if (half_x > 0 && cyc_n % half_x == 0) txclk_pin = ~txclk_pin;
    end

    function automatic void clear_hist();
        h_s = '{0, 0, 0};
        h_r = '{0, 0, 0};
        h_x = '{0, 0, 0};
        h_f = '{0, 0, 0};
    endfunction

    // Reference model: history queues hold the pin as seen over the last
    // three rising edges (index 0 newest)
    always @(posedge clk) begin
        bit rs, fs, rr, rx, rf, tk, rsy;
        if (!rst_n) begin
            clear_hist();
            m_cnt = 0; m_live = 0; m_pend = 0; m_armed = 0;
            m_en = 0; m_fsg = 0; m_load = 0;
        end else begin
            rs = h_s[1] && !h_s[2];
            fs = !h_s[1] && h_s[2];
            rr = h_r[1] && !h_r[2];
            rx = h_x[1] && !h_x[2];
            rf = h_f[1] && !h_f[2];
            h_s.push_front(sclk_pin);  void'(h_s.pop_back());
            h_r.push_front(rxclk_pin); void'(h_r.pop_back());
            h_x.push_front(txclk_pin); void'(h_x.pop_back());
            h_f.push_front(rxfs_pin);  void'(h_f.pop_back());
            case (cfg_src_sel)
                2'b00: tk = cfg_sclk_fall ? fs : rs;
                2'b01: tk = 1;
                2'b10: tk = rr;
                default: tk = rx;
            endcase
            rsy = cfg_resync && (cfg_src_sel == 2'b00);
            m_en = 0;
            if (tk) begin
                if (rsy) begin
                    if (m_pend) begin
                        m_en = 1; m_live = 1; m_armed = 1; m_pend = 0; m_fsg = 0;
                    end else if (m_armed) begin
                        m_en = m_live; m_fsg = 1; m_armed = 0;
                    end else begin
                        m_en = m_live; m_fsg = 0;
                    end
                end else if (m_cnt == 0) begin
                    m_en = 1; m_live = 1; m_fsg = 1; m_cnt = int'(cfg_period);
                end else begin
                    m_en = m_live; m_fsg = 0; m_cnt = m_cnt - 1;
                end
            end
            if (rsy && rf) begin
                m_pend = 1; m_armed = 0;
            end
            m_load = xmit_load;
        end
    end

    task automatic check_bit(string what, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        bit exp_fsx;
        if (checking) begin
            exp_fsx = cfg_fsx_internal ? (cfg_fsx_gen ? m_fsg : m_load) : 1'b0;
            check_bit("bit_en", bit_en, m_en);
            check_bit("frame_pulse", frame_pulse, m_fsg);
            check_bit("fsx_out", fsx_out, exp_fsx);
        end
    end

    task automatic do_reset();
        checking = 0;
        half_s = 0; half_r = 0; half_x = 0;
        sclk_pin = 0; rxclk_pin = 0; txclk_pin = 0; rxfs_pin = 0; xmit_load = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        cur_req = "R10";
        check_bit("reset bit_en", bit_en, 1'b0);
        check_bit("reset frame_pulse", frame_pulse, 1'b0);
        check_bit("reset fsx_out", fsx_out, 1'b0);
        rst_n = 1;
        checking = 1;
    endtask

    task automatic set_cfg(logic [1:0] sel, bit fall, bit rsy, int per,
                           bit fint, bit fgen);
        cfg_src_sel = sel; cfg_sclk_fall = fall; cfg_resync = rsy;
        cfg_period = per[11:0]; cfg_fsx_internal = fint; cfg_fsx_gen = fgen;
    endtask

    task automatic pulse_fsr(int width);
        rxfs_pin = 1;
        repeat (width) @(negedge clk);
        rxfs_pin = 0;
    endtask

    initial begin
        // R10, R6, R4: system clock source, first boundary right after reset
        set_cfg(2'b01, 0, 0, 3, 1, 1);
        do_reset();
        cur_req = "R6/R4";
        @(negedge clk);
        check_bit("first boundary bit_en", bit_en, 1'b1);
        check_bit("first boundary frame_pulse", frame_pulse, 1'b1);
        cur_req = "R4/R5/R9";
        repeat (60) @(negedge clk);

        // R4, R5: zero period keeps the marker high
        set_cfg(2'b01, 0, 0, 0, 0, 0);
        do_reset();
        cur_req = "R4/R5";
        repeat (30) @(negedge clk);

        // R1, R3, R5, R6: general pin, rising edges
        set_cfg(2'b00, 0, 0, 2, 1, 1);
        do_reset();
        cur_req = "R1/R3/R5/R6";
        half_s = 3;
        repeat (150) @(negedge clk);

        // R2: general pin, falling edges
        set_cfg(2'b00, 1, 0, 4, 1, 1);
        do_reset();
        cur_req = "R2/R3/R5";
        half_s = 4;
        repeat (160) @(negedge clk);

        // R1, R2, R8: receive clock; polarity and resync have no effect
        set_cfg(2'b10, 1, 1, 1, 1, 1);
        do_reset();
        cur_req = "R1/R2/R8";
        half_r = 2;
        half_s = 3;
        repeat (40) @(negedge clk);
        pulse_fsr(3);
        repeat (50) @(negedge clk);
        pulse_fsr(3);
        repeat (60) @(negedge clk);

        // R1, R5: transmit clock
        set_cfg(2'b11, 0, 0, 3, 1, 1);
        do_reset();
        cur_req = "R1/R5";
        half_x = 5;
        repeat (160) @(negedge clk);

        // R7: resync on the general pin
        set_cfg(2'b00, 0, 1, 5, 1, 1);
        do_reset();
        cur_req = "R7";
        half_s = 3;
        repeat (40) @(negedge clk);
        check_bit("no output before rx frame sync", bit_en | frame_pulse, 1'b0);
        pulse_fsr(4);
        repeat (60) @(negedge clk);
        pulse_fsr(2);
        repeat (60) @(negedge clk);

        // R9: transmit frame sync from the load strobe
        set_cfg(2'b01, 0, 0, 2, 1, 0);
        do_reset();
        cur_req = "R9";
        for (int k = 0; k < 6; k++) begin
            repeat (3 + k) @(negedge clk);
            xmit_load = 1;
            @(negedge clk);
            xmit_load = 0;
        end
        repeat (5) @(negedge clk);

        // R9: transmit frame sync from outside
        set_cfg(2'b01, 0, 0, 2, 0, 1);
        do_reset();
        cur_req = "R9";
        for (int k = 0; k < 4; k++) begin
            repeat (4) @(negedge clk);
            xmit_load = 1;
            @(negedge clk);
            xmit_load = 0;
        end
        repeat (10) @(negedge clk);

        checking = 0;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule